// File: doc/BRIEF.md
# Byte-Stream Command Frame Parser

The parser sits between a host byte channel and a spiking neural array. Bytes arrive one per handshake and group into frames. The first byte of a frame is an opcode, and that opcode fixes how many operand bytes follow. Once the last operand byte is in, the parser splits the operand bytes into named fields. It then either pulses a single configuration write toward the array, or starts a run of the timestep engine, or samples the engine's status. It answers over an outgoing byte channel.

Multi-byte fields arrive most significant byte first. Some frames pack the two high bits of 10-bit neuron numbers, or a small format code, into a flags byte. The parser unpacks these. Fields that an opcode does not use are driven to zero. The parser accepts no input bytes from the end of a frame until the last byte of its response has been taken. A host therefore never has to handle a second frame while a run is in progress.

The state machine has five states. IDLE waits for an opcode. COLLECT gathers operand bytes. EXEC lasts one cycle and issues the write, the run start or the status capture. RUNWAIT waits for the engine to report completion. RESP drains the response bytes. The transitions are:
- IDLE→COLLECT on a known opcode that has operands.
- IDLE→EXEC on the status opcode, which has no operands.
- IDLE→IDLE on an unknown byte.
- COLLECT→EXEC when the last operand byte is accepted.
- EXEC→RUNWAIT for a run.
- EXEC→RESP for any other command.
- RUNWAIT→RESP when the engine reports done.
- RESP→IDLE when the last response byte is accepted.

Top module: `cmd_frame_parser`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, cfg_we and run_start are 0.
- R2: Total frame lengths in bytes, opcode included, are: 0x01→9, 0x02→10, 0x03→6, 0x04→3, 0x05→1, 0x06→2, 0x07→7, 0x08→8, 0x09→3, 0x0A→5, 0x0C→7, 0x10→10. For every opcode other than 0x04 and 0x05, exactly one single-cycle cfg_we pulse follows the last byte. cfg_op carries the opcode during that pulse, and cfg_we and run_start are never high together.
- R3: Each configuration write is answered with exactly one byte, 0xAA, and that byte is presented in the cycle after cfg_we.
- R4: For opcode 0x01 the operand bytes are b1..b8. cfg_core=b1 and cfg_index={b2,b3}. Byte b4 is a flags byte. Its bits [7:6] give cfg_sel (the compartment). Its bits [5:4] prefix b5 to form the 10-bit cfg_src, and its bits [3:2] prefix b6 to form the 10-bit cfg_dst. cfg_data={b7,b8}.
- R5: For opcode 0x08, cfg_core=b1, cfg_index={b2,b3} and cfg_dst={b4,b5}. cfg_sel takes b6[7:6], and the 14-bit cfg_data is {b6[5:0],b7}.
- R6: Opcode 0x07 gives cfg_core=b1, cfg_index={b2,b3}, cfg_sel=b4 and cfg_data={b5,b6}. Opcode 0x03 gives cfg_core=b1, cfg_index={b2,b3} and cfg_data={b4,b5}. Opcode 0x09 gives cfg_data={b1,b2}.
- R7: Opcodes 0x02 and 0x10 give cfg_core=b1, cfg_src={b2,b3}, cfg_sel=b4, cfg_dcore=b5, cfg_dst={b6,b7} and cfg_data={b8,b9}.
- R8: Three opcodes keep only the low six bits of one byte in cfg_sel. For 0x06 it is b1; its bits 0 to 5 are the learn, graded, dendritic, async, three-factor and noise enables. For 0x0A it is b4 (the delay), with cfg_core=b1 and cfg_index={b2,b3}. For 0x0C it is b2 (the address), with cfg_core=b1 and cfg_data={b3,b4,b5,b6}.
- R9: Opcode 0x04 pulses run_start for one cycle with run_steps={b1,b2}. After run_done the response is 0xDD followed by the four bytes of run_spikes, most significant first.
- R10: Opcode 0x05 answers with five bytes: 0x00 if eng_busy is low, else 0x01, followed by eng_steps most significant byte first.
- R11: A byte that is none of the twelve opcodes is consumed, starts no write, run or response, and leaves the parser waiting for an opcode.
- R12: in_ready is 0 from the cycle after a frame's last byte until the last response byte has been accepted, including the whole run wait.
- R13: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming byte offered |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Parser can take a byte |
| out_valid | output | 1 | Response byte offered |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Receiver takes the response byte |
| cfg_we | output | 1 | One-cycle configuration write strobe |
| cfg_op | output | 8 | Opcode of the write |
| cfg_core | output | 8 | Core number field |
| cfg_index | output | 16 | Neuron or pool address field |
| cfg_sel | output | 8 | Selector: parameter, slot, compartment, format, delay, address or enables |
| cfg_src | output | 16 | Source neuron field |
| cfg_dcore | output | 8 | Destination core field |
| cfg_dst | output | 16 | Destination neuron or base address field |
| cfg_data | output | 32 | Value, weight, count or instruction field |
| run_start | output | 1 | One-cycle run request |
| run_steps | output | 16 | Timesteps requested, valid with run_start |
| run_done | input | 1 | One-cycle run completion |
| run_spikes | input | 32 | Spike total, valid with run_done |
| eng_busy | input | 1 | Engine busy indication |
| eng_steps | input | 32 | Executed timestep count |

## Verification
The assertions rely on two assumptions about the engine. It raises run_done only while a run started by this parser is outstanding, and only for one cycle. The bench's engine model follows this: it answers each run_start with a single done pulse after a fixed delay and never otherwise. The assertions also assume that the input side keeps a byte offered until it is accepted. The bench holds in_valid and in_data steady until in_ready is seen high. Response stalls come from the bench lowering out_ready on purpose, which exercises the hold rule against a real backlog.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    localparam int BYTE_W   = 8;
    localparam int OPND_MAX = 9;
    localparam int RESP_MAX = 5;
    localparam int CNT_W    = $clog2(OPND_MAX + 1);
    localparam int RLEN_W   = $clog2(RESP_MAX + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_POOL   = 8'h01;
    localparam byte_t OP_ROUTE  = 8'h02;
    localparam byte_t OP_STIM   = 8'h03;
    localparam byte_t OP_RUN    = 8'h04;
    localparam byte_t OP_STAT   = 8'h05;
    localparam byte_t OP_LCFG   = 8'h06;
    localparam byte_t OP_NEUR   = 8'h07;
    localparam byte_t OP_INDEX  = 8'h08;
    localparam byte_t OP_REWARD = 8'h09;
    localparam byte_t OP_DELAY  = 8'h0A;
    localparam byte_t OP_LPROG  = 8'h0C;
    localparam byte_t OP_GROUTE = 8'h10;

    localparam byte_t RESP_ACK  = 8'hAA;
    localparam byte_t RESP_DONE = 8'hDD;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COLLECT,
        S_EXEC,
        S_RUNWAIT,
        S_RESP
    } state_e;

    typedef struct packed {
        byte_t       core;
        logic [15:0] index;
        byte_t       sel;
        logic [15:0] src;
        byte_t       dcore;
        logic [15:0] dst;
        logic [31:0] data;
    } fields_t;
endpackage

// File: rtl/cfp_oplen.sv
module cfp_oplen
    import cfp_pkg::*;
(
    input  byte_t            op,
    output logic             known,
    output logic [CNT_W-1:0] nopnd
);
    always_comb begin
        known = 1'b1;
        case (op)
            OP_POOL:   nopnd = CNT_W'(8);
            OP_ROUTE:  nopnd = CNT_W'(9);
            OP_STIM:   nopnd = CNT_W'(5);
            OP_RUN:    nopnd = CNT_W'(2);
            OP_STAT:   nopnd = CNT_W'(0);
            OP_LCFG:   nopnd = CNT_W'(1);
            OP_NEUR:   nopnd = CNT_W'(6);
            OP_INDEX:  nopnd = CNT_W'(7);
            OP_REWARD: nopnd = CNT_W'(2);
            OP_DELAY:  nopnd = CNT_W'(4);
            OP_LPROG:  nopnd = CNT_W'(6);
            OP_GROUTE: nopnd = CNT_W'(9);
            default: begin
                known = 1'b0;
                nopnd = '0;
            end
        endcase
    end
endmodule

// File: rtl/cfp_field_decode.sv
module cfp_field_decode
    import cfp_pkg::*;
(
    input  byte_t                  op,
    input  byte_t [OPND_MAX-1:0]   opnd,
    output fields_t                f
);
    always_comb begin
        f = '0;
        case (op)
            OP_POOL: begin
                f.core  = opnd[0];
                f.index = {opnd[1], opnd[2]};
                f.sel   = {6'b0, opnd[3][7:6]};
                f.src   = {6'b0, opnd[3][5:4], opnd[4]};
                f.dst   = {6'b0, opnd[3][3:2], opnd[5]};
                f.data  = {16'b0, opnd[6], opnd[7]};
            end
            OP_ROUTE, OP_GROUTE: begin
                f.core  = opnd[0];
                f.src   = {opnd[1], opnd[2]};
                f.sel   = opnd[3];
                f.dcore = opnd[4];
                f.dst   = {opnd[5], opnd[6]};
                f.data  = {16'b0, opnd[7], opnd[8]};
            end
            OP_STIM: begin
                f.core  = opnd[0];
                f.index = {opnd[1], opnd[2]};
                f.data  = {16'b0, opnd[3], opnd[4]};
            end
            OP_NEUR: begin
                f.core  = opnd[0];
                f.index = {opnd[1], opnd[2]};
                f.sel   = opnd[3];
                f.data  = {16'b0, opnd[4], opnd[5]};
            end
            OP_INDEX: begin
                f.core  = opnd[0];
                f.index = {opnd[1], opnd[2]};
                f.dst   = {opnd[3], opnd[4]};
                f.sel   = {6'b0, opnd[5][7:6]};
                f.data  = {18'b0, opnd[5][5:0], opnd[6]};
            end
            OP_REWARD: f.data = {16'b0, opnd[0], opnd[1]};
            OP_LCFG:   f.sel  = {2'b0, opnd[0][5:0]};
            OP_DELAY: begin
                f.core  = opnd[0];
                f.index = {opnd[1], opnd[2]};
                f.sel   = {2'b0, opnd[3][5:0]};
            end
            OP_LPROG: begin
                f.core  = opnd[0];
                f.sel   = {2'b0, opnd[1][5:0]};
                f.data  = {opnd[2], opnd[3], opnd[4], opnd[5]};
            end
            default: f = '0;
        endcase
    end
endmodule

// File: rtl/cfp_resp_shift.sv
module cfp_resp_shift
    import cfp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  byte_t [RESP_MAX-1:0] load_bytes,
    input  logic [RLEN_W-1:0]    load_len,
    input  logic                 out_ready,
    output logic                 out_valid,
    output byte_t                out_data,
    output logic                 last_take
);
    byte_t [RESP_MAX-1:0] sh_q;
    logic  [RLEN_W-1:0]   left_q;

    assign out_valid = (left_q != '0);
    assign out_data  = sh_q[0];
    assign last_take = out_valid && out_ready && (left_q == RLEN_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= load_bytes;
            left_q <= load_len;
        end else if (out_valid && out_ready) begin
            for (int i = 0; i < RESP_MAX - 1; i++) begin
                sh_q[i] <= sh_q[i+1];
            end
            sh_q[RESP_MAX-1] <= '0;
            left_q <= left_q - RLEN_W'(1);
        end
    end
endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
    import cfp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready,
    output logic        cfg_we,
    output logic [7:0]  cfg_op,
    output logic [7:0]  cfg_core,
    output logic [15:0] cfg_index,
    output logic [7:0]  cfg_sel,
    output logic [15:0] cfg_src,
    output logic [7:0]  cfg_dcore,
    output logic [15:0] cfg_dst,
    output logic [31:0] cfg_data,
    output logic        run_start,
    output logic [15:0] run_steps,
    input  logic        run_done,
    input  logic [31:0] run_spikes,
    input  logic        eng_busy,
    input  logic [31:0] eng_steps
);
    state_e               state_q, state_d;
    byte_t                op_q;
    logic [CNT_W-1:0]     need_q, cnt_q;
    byte_t [OPND_MAX-1:0] opnd_q;

    logic                 op_known;
    logic [CNT_W-1:0]     op_nopnd;
    logic                 accept;
    logic                 resp_load, last_take;
    byte_t [RESP_MAX-1:0] resp_bytes;
    logic [RLEN_W-1:0]    resp_len;
    fields_t              fld;

    cfp_oplen u_len (
        .op    (in_data),
        .known (op_known),
        .nopnd (op_nopnd)
    );

    cfp_field_decode u_dec (
        .op   (op_q),
        .opnd (opnd_q),
        .f    (fld)
    );

    cfp_resp_shift u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (resp_load),
        .load_bytes (resp_bytes),
        .load_len   (resp_len),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .last_take  (last_take)
    );

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:
                if (accept && op_known)
                    state_d = (op_nopnd == '0) ? S_EXEC : S_COLLECT;
            S_COLLECT:
                if (accept && (cnt_q == need_q - CNT_W'(1)))
                    state_d = S_EXEC;
            S_EXEC:
                state_d = (op_q == OP_RUN) ? S_RUNWAIT : S_RESP;
            S_RUNWAIT:
                if (run_done) state_d = S_RESP;
            S_RESP:
                if (last_take) state_d = S_IDLE;
            default:
                state_d = S_IDLE;
        endcase
    end

    always_comb begin
        in_ready   = (state_q == S_IDLE) || (state_q == S_COLLECT);
        cfg_we     = 1'b0;
        run_start  = 1'b0;
        resp_load  = 1'b0;
        resp_bytes = '0;
        resp_len   = '0;
        unique case (state_q)
            S_EXEC: begin
                if (op_q == OP_RUN) begin
                    run_start = 1'b1;
                end else if (op_q == OP_STAT) begin
                    resp_load  = 1'b1;
                    resp_len   = RLEN_W'(5);
                    resp_bytes[0] = {7'b0, eng_busy};
                    resp_bytes[1] = eng_steps[31:24];
                    resp_bytes[2] = eng_steps[23:16];
                    resp_bytes[3] = eng_steps[15:8];
                    resp_bytes[4] = eng_steps[7:0];
                end else begin
                    cfg_we     = 1'b1;
                    resp_load  = 1'b1;
                    resp_len   = RLEN_W'(1);
                    resp_bytes[0] = RESP_ACK;
                end
            end
            S_RUNWAIT: begin
                if (run_done) begin
                    resp_load  = 1'b1;
                    resp_len   = RLEN_W'(5);
                    resp_bytes[0] = RESP_DONE;
                    resp_bytes[1] = run_spikes[31:24];
                    resp_bytes[2] = run_spikes[23:16];
                    resp_bytes[3] = run_spikes[15:8];
                    resp_bytes[4] = run_spikes[7:0];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            need_q <= '0;
            cnt_q  <= '0;
            opnd_q <= '0;
        end else if (accept) begin
            if (state_q == S_IDLE) begin
                op_q   <= in_data;
                need_q <= op_nopnd;
                cnt_q  <= '0;
                opnd_q <= '0;
            end else begin
                opnd_q[cnt_q] <= in_data;
                cnt_q         <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cfg_op    = op_q;
    assign cfg_core  = fld.core;
    assign cfg_index = fld.index;
    assign cfg_sel   = fld.sel;
    assign cfg_src   = fld.src;
    assign cfg_dcore = fld.dcore;
    assign cfg_dst   = fld.dst;
    assign cfg_data  = fld.data;
    assign run_steps = {opnd_q[0], opnd_q[1]};
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_ready,
    input logic       cfg_we,
    input logic       run_start,
    input logic       run_done
);
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cfg_we);

    p_excl_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && run_start));

    p_ack_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (out_valid && out_data == 8'hAA));

    p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !out_valid && !in_ready) |=> (out_valid && out_data == 8'hDD));

    p_run_holds_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> !in_ready);

    p_resp_blocks_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_hold_out_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind cmd_frame_parser cfp_checker u_cfp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .cfg_we    (cfg_we),
    .run_start (run_start),
    .run_done  (run_done)
);

// File: tb/cmd_frame_parser_test.sv
module cmd_frame_parser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        cfg_we;
    logic [7:0]  cfg_op, cfg_core, cfg_sel, cfg_dcore;
    logic [15:0] cfg_index, cfg_src, cfg_dst;
    logic [31:0] cfg_data;
    logic        run_start;
    logic [15:0] run_steps;
    logic        run_done = 1'b0;
    logic [31:0] run_spikes = '0;
    logic        eng_busy = 1'b0;
    logic [31:0] eng_steps = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0]  rx_q[$];
    int          cfg_cnt = 0;
    logic [7:0]  c_op, c_core, c_sel, c_dcore;
    logic [15:0] c_index, c_src, c_dst;
    logic [31:0] c_data;
    int          run_cnt = 0;
    logic [15:0] c_steps = '0;

    always #5 clk = ~clk;

    cmd_frame_parser uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_core(cfg_core),
        .cfg_index(cfg_index), .cfg_sel(cfg_sel), .cfg_src(cfg_src),
        .cfg_dcore(cfg_dcore), .cfg_dst(cfg_dst), .cfg_data(cfg_data),
        .run_start(run_start), .run_steps(run_steps),
        .run_done(run_done), .run_spikes(run_spikes),
        .eng_busy(eng_busy), .eng_steps(eng_steps)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) rx_q.push_back(out_data);
        if (rst_n && cfg_we) begin
            cfg_cnt++;
            c_op = cfg_op; c_core = cfg_core; c_index = cfg_index;
            c_sel = cfg_sel; c_src = cfg_src; c_dcore = cfg_dcore;
            c_dst = cfg_dst; c_data = cfg_data;
        end
    end

    // engine model: one done pulse, ten cycles after each run request
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && run_start) begin
                run_cnt++;
                c_steps = run_steps;
                repeat (10) @(negedge clk);
                run_spikes = 32'h0102_0304;
                run_done = 1'b1;
                @(negedge clk);
                run_done = 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [79:0] fr, input int n);
        for (int k = 0; k < n; k++) send_byte(fr[79-8*k -: 8]);
    endtask

    task automatic expect_resp(input string req, input logic [79:0] exp, input int n);
        logic [79:0] got = '0;
        int w = 0;
        while (rx_q.size() < n && w < 300) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        check(req, "response length", 80'(rx_q.size()), 80'(n));
        for (int i = 0; i < n && rx_q.size() > 0; i++) got = {got[71:0], rx_q.pop_front()};
        check(req, "response bytes", got, exp);
        rx_q.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "in_ready", 80'(in_ready), 80'(1));
        check("R1", "out_valid", 80'(out_valid), 80'(0));
        check("R1", "cfg_we", 80'(cfg_we), 80'(0));
        check("R1", "run_start", 80'(run_start), 80'(0));
    endtask

    task automatic t_pool();
        int c0 = cfg_cnt;
        send_frame(80'h01_03_01_23_B4_45_67_89_AB_00, 9);
        expect_resp("R3", 80'hAA, 1);
        check("R2", "one strobe", 80'(cfg_cnt - c0), 80'(1));
        check("R2", "opcode", 80'(c_op), 80'h01);
        check("R4", "core", 80'(c_core), 80'h03);
        check("R4", "index", 80'(c_index), 80'h0123);
        check("R4", "compartment", 80'(c_sel), 80'h2);
        check("R4", "src", 80'(c_src), 80'h345);
        check("R4", "dst", 80'(c_dst), 80'h167);
        check("R4", "weight", 80'(c_data), 80'h89AB);
    endtask

    task automatic t_index();
        send_frame(80'h08_05_00_10_02_00_6A_5C_00_00, 8);
        expect_resp("R3", 80'hAA, 1);
        check("R5", "core", 80'(c_core), 80'h05);
        check("R5", "neuron", 80'(c_index), 80'h0010);
        check("R5", "base", 80'(c_dst), 80'h0200);
        check("R5", "format", 80'(c_sel), 80'h1);
        check("R5", "count", 80'(c_data), 80'h2A5C);
    endtask

    task automatic t_neur_stim_reward();
        send_frame(80'h07_02_03_FF_16_04_B0_00_00_00, 7);
        expect_resp("R3", 80'hAA, 1);
        check("R6", "neuron param", 80'({c_core, c_index, c_sel, c_data}),
              80'({8'h02, 16'h03FF, 8'h16, 32'h04B0}));
        send_frame(80'h03_00_00_09_12_34_00_00_00_00, 6);
        expect_resp("R3", 80'hAA, 1);
        check("R6", "stimulus", 80'({c_op, c_index, c_sel, c_data}),
              80'({8'h03, 16'h0009, 8'h00, 32'h1234}));
        send_frame(80'h09_FF_38_00_00_00_00_00_00_00, 3);
        expect_resp("R3", 80'hAA, 1);
        check("R6", "reward", 80'({c_op, c_core, c_data}), 80'({8'h09, 8'h00, 32'hFF38}));
    endtask

    task automatic t_route();
        send_frame(80'h02_00_00_03_01_01_00_00_04_B0, 10);
        expect_resp("R3", 80'hAA, 1);
        check("R7", "route", 80'({c_core, c_src, c_sel, c_dcore, c_dst, c_data[15:0]}),
              80'({8'h00, 16'h0003, 8'h01, 8'h01, 16'h0000, 16'h04B0}));
        send_frame(80'h10_0E_01_02_07_0F_03_04_12_34, 10);
        expect_resp("R3", 80'hAA, 1);
        check("R7", "global route", 80'({c_core, c_src, c_sel, c_dcore, c_dst, c_data[15:0]}),
              80'({8'h0E, 16'h0102, 8'h07, 8'h0F, 16'h0304, 16'h1234}));
        check("R2", "global opcode", 80'(c_op), 80'h10);
    endtask

    task automatic t_six_bit();
        send_frame(80'h06_E5_00_00_00_00_00_00_00_00, 2);
        expect_resp("R3", 80'hAA, 1);
        check("R8", "enables", 80'(c_sel), 80'h25);
        send_frame(80'h0A_01_00_07_FF_00_00_00_00_00, 5);
        expect_resp("R3", 80'hAA, 1);
        check("R8", "delay", 80'({c_core, c_index, c_sel}), 80'({8'h01, 16'h0007, 8'h3F}));
        send_frame(80'h0C_02_C7_DE_AD_BE_EF_00_00_00, 7);
        expect_resp("R3", 80'hAA, 1);
        check("R8", "learn prog", 80'({c_core, c_sel, c_data}),
              80'({8'h02, 8'h07, 32'hDEADBEEF}));
    endtask

    task automatic t_run();
        int c0 = cfg_cnt;
        bit held = 1;
        eng_busy  = 1'b0;
        eng_steps = 32'h0000_0014;
        send_frame(80'h04_00_14_00_00_00_00_00_00_00, 3);
        @(negedge clk);
        in_data  = 8'h05;
        in_valid = 1'b1;
        repeat (5) begin
            if (in_ready) held = 0;
            @(negedge clk);
        end
        check("R12", "input held during run", 80'(held), 80'(1));
        while (!in_ready) @(negedge clk);
        check("R12", "DONE drained before next byte", 80'(rx_q.size()), 80'(5));
        @(negedge clk);
        in_valid = 1'b0;
        expect_resp("R9", 80'hDD_01_02_03_04_00_00_00_00_14, 10);
        check("R9", "one run request", 80'(run_cnt), 80'(1));
        check("R9", "steps", 80'(c_steps), 80'h0014);
        check("R2", "no write for run/status", 80'(cfg_cnt - c0), 80'(0));
    endtask

    task automatic t_status();
        eng_busy  = 1'b1;
        eng_steps = 32'hCAFE_0012;
        send_frame(80'h05_00_00_00_00_00_00_00_00_00, 1);
        expect_resp("R10", 80'h01_CA_FE_00_12, 5);
        eng_busy = 1'b0;
    endtask

    task automatic t_unknown();
        int c0 = cfg_cnt;
        int r0 = run_cnt;
        send_byte(8'h0B);
        send_byte(8'hFF);
        repeat (4) @(negedge clk);
        check("R11", "no response", 80'({out_valid, 8'(rx_q.size())}), 80'(0));
        check("R11", "still accepting", 80'(in_ready), 80'(1));
        check("R11", "no write or run", 80'({16'(cfg_cnt - c0), 16'(run_cnt - r0)}), 80'(0));
        eng_steps = 32'h0000_0009;
        send_frame(80'h05_00_00_00_00_00_00_00_00_00, 1);
        expect_resp("R11", 80'h00_00_00_00_09, 5);
    endtask

    task automatic t_stall();
        bit ok = 1;
        out_ready = 1'b0;
        send_frame(80'h07_01_00_02_03_00_05_00_00_00, 7);
        while (!out_valid) @(negedge clk);
        repeat (4) begin
            if (!out_valid || out_data !== 8'hAA || in_ready) ok = 0;
            @(negedge clk);
        end
        check("R13", "held response", 80'(ok), 80'(1));
        out_ready = 1'b1;
        expect_resp("R13", 80'hAA, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pool();
        t_index();
        t_neur_stim_reward();
        t_route();
        t_six_bit();
        t_run();
        t_status();
        t_unknown();
        t_stall();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule